// File: doc/BRIEF.md
# Audio Interface Clock Generator

This block produces the bit clock and the two frame clocks (one for the ADC path, one for the DAC path) of an audio serial port from a single system clock. The block runs on one core clock. The two possible sources of the system clock, a master clock and an alternate reference such as a frequency-locked loop output, arrive as one-cycle enable pulses on that core clock. A source select picks one of them. The master clock path can be halved first. Every pulse of the resulting system tick advances the bit-clock divider and both frame dividers.

The two converters have their own rate divider, so their sample rates are independent. Two frame ratios are available. In normal mode one frame lasts 256 divided system ticks. In 12 MHz-friendly mode it lasts 272. The bit-clock period is a power-of-two number of system ticks.

A resync strobe loads a new configuration and restarts every divider together, so the bit clock and both frame clocks always start in the same relative phase. If the new configuration would not put frame edges on bit-clock edges, the block raises an error, keeps running on the previous setting and does not restart. In slave mode the external bit and frame clocks are passed straight to the outputs.

Top module: `aif_clkgen`

## Requirements
- R1: `src_sel`=0 takes the system tick from `mclk_en`. `src_sel`=1 takes it from `ref_en`.
- R2: With `mclk_half`=1 and `src_sel`=0, only every second `mclk_en` pulse becomes a system tick. With `src_sel`=1, `mclk_half` has no effect.
- R3: In normal mode (`cfg_usb`=0), `adc_lrclk` has a period of (`cfg_adc_div`+1)×256 system ticks.
- R4: `dac_lrclk` has a period of (`cfg_dac_div`+1)×256 system ticks (×272 in the other mode), independent of `cfg_adc_div`.
- R5: With `cfg_usb`=1, both frame periods use 272 in place of 256.
- R6: In master mode, `bclk` has a period of 2^(`cfg_bclk_k`+1) system ticks at 50% duty.
- R7: Each frame clock has 50% duty and changes level only in a cycle where `bclk` goes from 1 to 0.
- R8: A valid resync restarts all dividers. In the sample after the resync edge all three outputs are 0. `bclk` first rises 2^k ticks later. Each frame clock first rises after half its frame period.
- R9: At a resync, `cfg_err` is set when either half-frame length, counted in system ticks, is not a multiple of the bit-clock period. In that case the old configuration stays active and nothing restarts. A later valid resync clears `cfg_err`. `cfg_err` changes only at a resync.
- R10: With `master`=0, `bclk`, `adc_lrclk` and `dac_lrclk` follow `ext_bclk`, `ext_adc_lr` and `ext_dac_lr` in the same cycle.
- R11: After reset, the outputs are 0 and `cfg_err` is 0. The active setting after reset is divider 0, normal mode and k=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mclk_en | input | 1 | One pulse per master-clock cycle |
| ref_en | input | 1 | One pulse per alternate-reference cycle |
| src_sel | input | 1 | System clock source: 0 master, 1 reference |
| mclk_half | input | 1 | Halve the master-clock path |
| master | input | 1 | 1 = generate clocks, 0 = pass external clocks |
| resync | input | 1 | Load configuration and restart dividers |
| cfg_usb | input | 1 | Frame ratio: 0 → 256, 1 → 272 |
| cfg_adc_div | input | DIV_W | ADC rate divider minus one |
| cfg_dac_div | input | DIV_W | DAC rate divider minus one |
| cfg_bclk_k | input | K_W | Bit-clock half period is 2^k system ticks |
| ext_bclk | input | 1 | External bit clock (slave) |
| ext_adc_lr | input | 1 | External ADC frame clock (slave) |
| ext_dac_lr | input | 1 | External DAC frame clock (slave) |
| bclk | output | 1 | Bit clock |
| adc_lrclk | output | 1 | ADC frame clock |
| dac_lrclk | output | 1 | DAC frame clock |
| cfg_err | output | 1 | Last resync carried an unaligned configuration |

## Verification
All master-mode outputs are registered. Each output changes on the clock edge that sees the tick completing its count, and `cfg_err` changes on the edge that samples `resync`. The dividers are already cleared in the sample taken after the resync edge. From that sample, the bench counts falling-edge samples until the first rise of each output and expects exactly 2^k or half a frame. Periods and high times are measured rise to rise on the same falling-edge grid, which keeps every count independent of process ordering at the active edge. Slave pass-through is combinational, so its checks look one time step after the external inputs change.

// File: rtl/aclk_pkg.sv
// Shared constants and the source-select encoding for the audio clock generator.
package aclk_pkg;
    typedef enum logic {
        SRC_MCLK = 1'b0,
        SRC_REF  = 1'b1
    } src_e;

    // Half of a frame, in divided system ticks, per clocking mode.
    localparam int unsigned HALF_NORMAL = 128;
    localparam int unsigned HALF_USB    = 136;
endpackage

// File: rtl/aclk_tick_sel.sv
// Forms the system tick from the selected source enable.
// Assumes mclk_en and ref_en are single-cycle pulses synchronous to clk.
// The halving phase restarts with the other dividers so that phase is repeatable.
module aclk_tick_sel
    import aclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic mclk_en,
    input  logic ref_en,
    input  logic src_sel,
    input  logic mclk_half,
    output logic tick
);
    logic half_ph_q;

    // Halving phase: flips on each master-clock pulse while that source is chosen.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            half_ph_q <= 1'b0;
        end else if (src_e'(src_sel) == SRC_MCLK && mclk_en) begin
            half_ph_q <= ~half_ph_q;
        end
    end

    // Tick selection: the reference path ignores the halving option.
    always_comb begin
        if (restart) begin
            tick = 1'b0;
        end else if (src_e'(src_sel) == SRC_REF) begin
            tick = ref_en;
        end else begin
            tick = mclk_en && (!mclk_half || half_ph_q);
        end
    end
endmodule

// File: rtl/aclk_toggle_div.sv
// Toggling divider: output inverts every (last+1) ticks.
// Assumes last is held constant between restarts. Restart clears the count and the output.
module aclk_toggle_div #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          tick,
    input  logic [CW-1:0] last,
    output logic          q
);
    logic [CW-1:0] cnt_q;

    // Count ticks and flip the output on the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
            q     <= 1'b0;
        end else if (tick) begin
            if (cnt_q >= last) begin
                cnt_q <= '0;
                q     <= ~q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/aclk_cfg_hold.sv
// Validates a requested configuration on resync and keeps the active one.
// Assumes HF_W can hold 2^DIV_W * 136 and 2^(2^K_W).
// An unaligned request sets err and leaves the active setting untouched.
module aclk_cfg_hold
    import aclk_pkg::*;
#(
    parameter int DIV_W = 4,
    parameter int K_W   = 3,
    parameter int HF_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             resync,
    input  logic             usb_in,
    input  logic [DIV_W-1:0] adc_div_in,
    input  logic [DIV_W-1:0] dac_div_in,
    input  logic [K_W-1:0]   k_in,
    output logic [HF_W-1:0]  frame_last [2],
    output logic [HF_W-1:0]  bclk_last,
    output logic             restart,
    output logic             err
);
    localparam int NCONV = 2;

    logic                  act_usb_q;
    logic [K_W-1:0]        act_k_q;
    logic [DIV_W-1:0]      act_div_q [NCONV];
    logic [DIV_W-1:0]      req_div   [NCONV];
    logic [NCONV-1:0]      req_ok;
    logic [HF_W-1:0]       req_mask;

    function automatic logic [HF_W-1:0] half_frame(input logic usb, input logic [DIV_W-1:0] d);
        return (HF_W'(d) + HF_W'(1)) * (usb ? HF_W'(HALF_USB) : HF_W'(HALF_NORMAL));
    endfunction

    assign req_div[0] = adc_div_in;
    assign req_div[1] = dac_div_in;
    assign req_mask   = (HF_W'(2) << k_in) - HF_W'(1);
    assign restart    = resync && (&req_ok);
    assign bclk_last  = (HF_W'(1) << act_k_q) - HF_W'(1);

    for (genvar g = 0; g < NCONV; g++) begin : g_conv
        // Alignment: half-frame must be a whole number of bit-clock periods.
        assign req_ok[g]     = (half_frame(usb_in, req_div[g]) & req_mask) == '0;
        assign frame_last[g] = half_frame(act_usb_q, act_div_q[g]) - HF_W'(1);

        // Active divider: loaded only by a valid resync.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_div_q[g] <= '0;
            end else if (restart) begin
                act_div_q[g] <= req_div[g];
            end
        end
    end

    // Active mode and bit-clock exponent, plus the error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_usb_q <= 1'b0;
            act_k_q   <= '0;
            err       <= 1'b0;
        end else if (resync) begin
            err <= ~(&req_ok);
            if (&req_ok) begin
                act_usb_q <= usb_in;
                act_k_q   <= k_in;
            end
        end
    end
endmodule

// File: rtl/aif_clkgen.sv
// Audio interface clock generator top.
// Derives the bit clock and the ADC/DAC frame clocks from one system tick.
// In slave mode it passes the external clocks through.
// Assumes all inputs are synchronous to clk.
module aif_clkgen #(
    parameter int DIV_W = 4,
    parameter int K_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mclk_en,
    input  logic             ref_en,
    input  logic             src_sel,
    input  logic             mclk_half,
    input  logic             master,
    input  logic             resync,
    input  logic             cfg_usb,
    input  logic [DIV_W-1:0] cfg_adc_div,
    input  logic [DIV_W-1:0] cfg_dac_div,
    input  logic [K_W-1:0]   cfg_bclk_k,
    input  logic             ext_bclk,
    input  logic             ext_adc_lr,
    input  logic             ext_dac_lr,
    output logic             bclk,
    output logic             adc_lrclk,
    output logic             dac_lrclk,
    output logic             cfg_err
);
    localparam int HF_A = DIV_W + 8;
    localparam int HF_B = (1 << K_W) + 1;
    localparam int HF_W = (HF_A > HF_B) ? HF_A : HF_B;

    logic            tick;
    logic            restart;
    logic [HF_W-1:0] frame_last [2];
    logic [HF_W-1:0] bclk_last;
    logic            bclk_int;
    logic [1:0]      lr_int;

    aclk_cfg_hold #(.DIV_W(DIV_W), .K_W(K_W), .HF_W(HF_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .resync(resync), .usb_in(cfg_usb),
        .adc_div_in(cfg_adc_div), .dac_div_in(cfg_dac_div), .k_in(cfg_bclk_k),
        .frame_last(frame_last), .bclk_last(bclk_last),
        .restart(restart), .err(cfg_err)
    );

    aclk_tick_sel u_tick (
        .clk(clk), .rst_n(rst_n), .restart(restart), .mclk_en(mclk_en),
        .ref_en(ref_en), .src_sel(src_sel), .mclk_half(mclk_half), .tick(tick)
    );

    aclk_toggle_div #(.CW(HF_W)) u_bclk (
        .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick),
        .last(bclk_last), .q(bclk_int)
    );

    for (genvar c = 0; c < 2; c++) begin : g_frame
        aclk_toggle_div #(.CW(HF_W)) u_lr (
            .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick),
            .last(frame_last[c]), .q(lr_int[c])
        );
    end

    // Output select: generated clocks in master mode, external ones otherwise.
    always_comb begin
        bclk      = master ? bclk_int  : ext_bclk;
        adc_lrclk = master ? lr_int[0] : ext_adc_lr;
        dac_lrclk = master ? lr_int[1] : ext_dac_lr;
    end
endmodule

// File: rtl/aif_clkgen_chk.sv
// Temporal checks on the clock generator ports, bound to every aif_clkgen.
module aif_clkgen_chk (
    input logic clk,
    input logic rst_n,
    input logic master,
    input logic resync,
    input logic mclk_en,
    input logic ref_en,
    input logic bclk,
    input logic adc_lrclk,
    input logic dac_lrclk,
    input logic cfg_err
);
    // R7: ADC frame clock moves only together with a falling bit clock.
    a_r7_adc_on_bclk_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (master && $past(master) && !$past(resync) && (adc_lrclk != $past(adc_lrclk)))
        |-> ($past(bclk) && !bclk));

    // R7: DAC frame clock moves only together with a falling bit clock.
    a_r7_dac_on_bclk_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (master && $past(master) && !$past(resync) && (dac_lrclk != $past(dac_lrclk)))
        |-> ($past(bclk) && !bclk));

    // R9: the error flag changes only at a resync.
    a_r9_err_only_on_resync: assert property (@(posedge clk) disable iff (!rst_n)
        !resync |=> $stable(cfg_err));

    // R1: without any source pulse, no generated clock moves.
    a_r1_no_tick_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (master && !resync && !mclk_en && !ref_en)
        |=> (!master || ($stable(bclk) && $stable(adc_lrclk) && $stable(dac_lrclk))));
endmodule

bind aif_clkgen aif_clkgen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .master(master), .resync(resync),
    .mclk_en(mclk_en), .ref_en(ref_en), .bclk(bclk),
    .adc_lrclk(adc_lrclk), .dac_lrclk(dac_lrclk), .cfg_err(cfg_err)
);

// File: tb/aif_clkgen_test.sv
`timescale 1ns/1ps
module aif_clkgen_test;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n, mclk_en, ref_en, src_sel, mclk_half, master, resync, cfg_usb;
    logic [3:0] cfg_adc_div, cfg_dac_div;
    logic [2:0] cfg_bclk_k;
    logic       ext_bclk, ext_adc_lr, ext_dac_lr;
    logic       bclk, adc_lrclk, dac_lrclk, cfg_err;

    int checks = 0;
    int fails  = 0;

    aif_clkgen uut (
        .clk(clk), .rst_n(rst_n), .mclk_en(mclk_en), .ref_en(ref_en),
        .src_sel(src_sel), .mclk_half(mclk_half), .master(master), .resync(resync),
        .cfg_usb(cfg_usb), .cfg_adc_div(cfg_adc_div), .cfg_dac_div(cfg_dac_div),
        .cfg_bclk_k(cfg_bclk_k), .ext_bclk(ext_bclk), .ext_adc_lr(ext_adc_lr),
        .ext_dac_lr(ext_dac_lr), .bclk(bclk), .adc_lrclk(adc_lrclk),
        .dac_lrclk(dac_lrclk), .cfg_err(cfg_err)
    );

    typedef struct packed {
        logic       src;
        logic       half;
        logic       usb;
        logic [3:0] adc;
        logic [3:0] dac;
        logic [2:0] k;
        logic       err;
        int         per_a;
        int         per_d;
        int         per_b;
    } vec_t;

    // Periods are in clk cycles; mclk_en pulses every cycle, ref_en every other cycle.
    localparam vec_t VECS [9] = '{
        '{1'b0, 1'b0, 1'b0, 4'd0,  4'd1,  3'd1, 1'b0, 256,  512,  4},
        '{1'b0, 1'b0, 1'b1, 4'd2,  4'd0,  3'd2, 1'b0, 816,  272,  8},
        '{1'b0, 1'b1, 1'b0, 4'd0,  4'd0,  3'd0, 1'b0, 512,  512,  4},
        '{1'b1, 1'b0, 1'b0, 4'd0,  4'd0,  3'd0, 1'b0, 512,  512,  4},
        '{1'b1, 1'b1, 1'b0, 4'd0,  4'd0,  3'd0, 1'b0, 512,  512,  4},
        '{1'b0, 1'b0, 1'b1, 4'd0,  4'd1,  3'd3, 1'b1, 256,  256,  2},
        '{1'b0, 1'b0, 1'b0, 4'd0,  4'd0,  3'd7, 1'b1, 256,  256,  2},
        '{1'b0, 1'b0, 1'b0, 4'd1,  4'd3,  3'd7, 1'b0, 512,  1024, 256},
        '{1'b0, 1'b0, 1'b1, 4'd15, 4'd15, 3'd3, 1'b0, 4352, 4352, 16}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    function automatic logic pick(input int s);
        case (s)
            0:       return bclk;
            1:       return adc_lrclk;
            default: return dac_lrclk;
        endcase
    endfunction

    // Measure period and high time rise to rise. Also count frame edges off a bclk fall.
    task automatic measure(input int s, output int per, output int hi, output int bad);
        int n = 0;
        logic pv, pb;
        per = 0; hi = 0; bad = 0;
        while (pick(s) !== 1'b0 && n < 20000) begin @(negedge clk); n++; end
        while (pick(s) !== 1'b1 && n < 20000) begin @(negedge clk); n++; end
        pv = 1'b1; pb = bclk;
        while (per < 20000) begin
            @(negedge clk);
            per++;
            if (pick(s)) hi++;
            if (s != 0 && pick(s) != pv && !(pb && !bclk)) bad++;
            if (pick(s) && !pv) break;
            pv = pick(s); pb = bclk;
        end
    endtask

    task automatic apply(input logic s, input logic h, input logic u,
                         input logic [3:0] a, input logic [3:0] d, input logic [2:0] k);
        @(negedge clk);
        src_sel = s; mclk_half = h; cfg_usb = u;
        cfg_adc_div = a; cfg_dac_div = d; cfg_bclk_k = k;
        resync = 1'b1;
        @(negedge clk);
        resync = 1'b0;
    endtask

    task automatic first_rise(input int s, output int n);
        n = 0;
        while (!pick(s) && n < 20000) begin @(negedge clk); n++; end
    endtask

    initial begin
        ref_en = 1'b0;
        forever begin
            @(negedge clk);
            ref_en = ~ref_en;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        int per, hi, bad, n;
        rst_n = 1'b0; mclk_en = 1'b1; src_sel = 1'b0; mclk_half = 1'b0;
        master = 1'b1; resync = 1'b0; cfg_usb = 1'b0;
        cfg_adc_div = '0; cfg_dac_div = '0; cfg_bclk_k = '0;
        ext_bclk = 1'b0; ext_adc_lr = 1'b0; ext_dac_lr = 1'b0;
        repeat (5) @(negedge clk);

        // R11: reset state.
        chk("R11 reset outputs", {bclk, adc_lrclk, dac_lrclk}, 0);
        chk("R11 reset err", cfg_err, 0);
        rst_n = 1'b1;
        measure(1, per, hi, bad);
        chk("R11 default adc period", per, 256);
        measure(0, per, hi, bad);
        chk("R11 default bclk period", per, 2);

        // R8: restart phase, one resync per measured output.
        apply(1'b0, 1'b0, 1'b0, 4'd0, 4'd1, 3'd1);
        chk("R8 outputs cleared", {bclk, adc_lrclk, dac_lrclk}, 0);
        first_rise(0, n);
        chk("R8 first bclk rise", n, 2);
        apply(1'b0, 1'b0, 1'b0, 4'd0, 4'd1, 3'd1);
        first_rise(1, n);
        chk("R8 first adc rise", n, 128);
        apply(1'b0, 1'b0, 1'b0, 4'd0, 4'd1, 3'd1);
        first_rise(2, n);
        chk("R8 first dac rise", n, 256);

        // R1 R2 R3 R4 R5 R6 R7 R9: configuration table.
        for (int i = 0; i < 9; i++) begin
            apply(VECS[i].src, VECS[i].half, VECS[i].usb, VECS[i].adc, VECS[i].dac, VECS[i].k);
            chk("R9 err flag", cfg_err, VECS[i].err);
            measure(0, per, hi, bad);
            chk("R6 bclk period", per, VECS[i].per_b);
            chk("R6 bclk high", hi, VECS[i].per_b / 2);
            measure(1, per, hi, bad);
            chk("R1/R2/R3/R5 adc period", per, VECS[i].per_a);
            chk("R7 adc high", hi, VECS[i].per_a / 2);
            chk("R7 adc edge on bclk fall", bad, 0);
            measure(2, per, hi, bad);
            chk("R4 dac period", per, VECS[i].per_d);
            chk("R7 dac edge on bclk fall", bad, 0);
        end

        // R10: slave pass-through of every external combination.
        master = 1'b0;
        for (int i = 0; i < 8; i++) begin
            {ext_bclk, ext_adc_lr, ext_dac_lr} = 3'(i);
            #1;
            chk("R10 slave pass", {bclk, adc_lrclk, dac_lrclk}, i);
            @(negedge clk);
        end
        master = 1'b1;

        finish_run();
    end
endmodule